// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Selector

This block divides a 32.768 kHz clock-enable tick down to one of thirteen binary rates and uses that rate in two ways. It drives a square-wave pin, and it raises a periodic-interrupt flag. A 4-bit rate code picks the divider stage. Two low codes are aliases of mid-range codes, and code zero stops both outputs. A fast-override control puts the undivided tick on the square-wave pin and holds the periodic interrupt off while it is set.

The host sets the rate code, the square-wave enable, the override and the flag enable as static control levels. It reads the status byte and pulses `status_read` to clear the flag. The periodic tick comes out as a one-cycle pulse for other logic on the chip.

Top module: `prdsel_top`

## Requirements
- R1: A free-running 14-stage binary counter advances by exactly one on every cycle in which `tick_32k` is 1, and returns to zero on reset.
- R2: For codes 3 to 15, `sqw_out` (when driven and not overridden) equals bit (code − 2) of the tick count. This gives a 50% duty square wave at 2^(16 − code) Hz, from 8192 Hz at code 3 down to 2 Hz at code 15.
- R3: Code 1 behaves exactly like code 8 (count bit 6), and code 2 behaves exactly like code 9 (count bit 7).
- R4: With code 0, `sqw_out` stays 0 (unless overridden), `periodic_tick` never pulses and the flag is never set.
- R5: `periodic_tick` is a one-cycle pulse. It appears in the cycle after a tick that moves the selected count bit from 0 to 1, and at no other time.
- R6: `sqw_drive` is 1 exactly when `sqw_enable` or `fast_override` is 1. While `sqw_drive` is 0, `sqw_out` is 0.
- R7: While `fast_override` is 1, `sqw_out` follows `tick_32k` in the same cycle for every code. In that state `periodic_tick` does not pulse, the flag is not set and `irq` is 0.
- R8: The flag sets on each `periodic_tick` pulse and clears in the cycle after `status_read` is 1. If a set and a read fall in the same cycle, the flag stays set.
- R9: `irq` = flag AND `pflag_enable` AND NOT `fast_override`. In `status_byte`, bit 7 is `irq`, bit 6 is the flag, and bits 5..0 always read 0.
- R10: After reset the flag, `periodic_tick`, `irq`, `status_byte` and `sqw_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| tick_32k | input | 1 | 32.768 kHz clock-enable pulse |
| rate_code | input | 4 | Rate-select code |
| sqw_enable | input | 1 | Square-wave output enable |
| fast_override | input | 1 | Put the raw tick on the square wave and block periodic interrupts |
| pflag_enable | input | 1 | Periodic interrupt enable |
| status_read | input | 1 | Status read strobe; clears the flag |
| sqw_out | output | 1 | Square-wave output level |
| sqw_drive | output | 1 | Square-wave pin output enable |
| periodic_tick | output | 1 | One-cycle pulse at the selected rate |
| irq | output | 1 | Periodic interrupt request |
| status_byte | output | 8 | {irq, flag, 6'b0} |

## Verification
A vector table steps through every nonzero code while a model tick counter predicts each `sqw_out` level and each `periodic_tick` pulse. A wrong stage index shows up as a wrong phase or a wrong pulse spacing, and a wrong alias target shows up the same way on codes 1 and 2. Directed patterns then separate the square-wave gating from the periodic path: code 0, output disabled with ticks still running, and override with both code 0 and a live code. Further directed patterns check the flag's read-clear, a read that coincides with a set, the enable masking and a reset taken mid-stream.

// File: rtl/prdsel_pkg.sv
package prdsel_pkg;

    localparam int RATE_W         = 4;
    localparam int DIV_W          = 14;
    // Code c (above the aliases) takes divider stage c - STAGE_OFFSET
    localparam int STAGE_OFFSET   = 2;
    localparam int ALIAS_A_CODE   = 1;
    localparam int ALIAS_A_TARGET = 8;
    localparam int ALIAS_B_CODE   = 2;
    localparam int ALIAS_B_TARGET = 9;
    localparam int STATUS_W       = 8;

    typedef struct packed {
        logic flag;
        logic tick;
    } flag_state_t;

endpackage

// File: rtl/prdsel_rate_decode.sv
module prdsel_rate_decode
    import prdsel_pkg::*;
#(
    parameter int CODE_W = RATE_W,
    parameter int STG_N  = DIV_W,
    localparam int SEL_W = $clog2(STG_N)
) (
    input  logic [CODE_W-1:0] code,
    output logic [SEL_W-1:0]  stage,
    output logic              active
);

    int eff_code;
    int stage_idx;

    always_comb begin
        eff_code = int'(code);
        if (eff_code == ALIAS_A_CODE) begin
            eff_code = ALIAS_A_TARGET;
        end else if (eff_code == ALIAS_B_CODE) begin
            eff_code = ALIAS_B_TARGET;
        end
        stage_idx = eff_code - STAGE_OFFSET;
        active    = (code != '0) && (stage_idx >= 0) && (stage_idx < STG_N);
        stage     = active ? SEL_W'(stage_idx) : '0;
    end

endmodule

// File: rtl/prdsel_divider.sv
module prdsel_divider
    import prdsel_pkg::*;
#(
    parameter int STG_N = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [STG_N-1:0] count,
    output logic [STG_N-1:0] rise
);

    logic [STG_N-1:0] cnt_d, cnt_q;
    logic [STG_N-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + STG_N'(1);
        cnt_d   = tick ? cnt_inc : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // A stage rises when this tick's increment carries into a bit that is 0
    for (genvar g = 0; g < STG_N; g++) begin : g_rise
        assign rise[g] = tick & ~cnt_q[g] & cnt_inc[g];
    end

    assign count = cnt_q;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) && $past(rst_n) |-> count == STG_N'($past(count) + STG_N'(1)));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) && $past(rst_n) |-> $stable(count));

endmodule

// File: rtl/prdsel_flag.sv
module prdsel_flag
    import prdsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_sel,
    input  logic active,
    input  logic override,
    input  logic pie,
    input  logic stat_rd,
    output logic ptick,
    output logic flag,
    output logic irq
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = rise_sel & active & ~override;
        if (stat_rd) begin
            st_d.flag = 1'b0;
        end
        if (st_d.tick) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptick = st_q.tick;
    assign flag  = st_q.flag;
    assign irq   = st_q.flag & pie & ~override;

    // R8
    flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ptick);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_rd) && $past(rst_n) && !ptick |-> !flag);

    // R7
    override_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(override) |-> !ptick);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag && pie && !override);

endmodule

// File: rtl/prdsel_top.sv
module prdsel_top
    import prdsel_pkg::*;
#(
    parameter int CODE_W = RATE_W,
    parameter int STG_N  = DIV_W,
    localparam int SEL_W = $clog2(STG_N),
    localparam int PAD_W = 1 << SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_32k,
    input  logic [CODE_W-1:0]   rate_code,
    input  logic                sqw_enable,
    input  logic                fast_override,
    input  logic                pflag_enable,
    input  logic                status_read,
    output logic                sqw_out,
    output logic                sqw_drive,
    output logic                periodic_tick,
    output logic                irq,
    output logic [STATUS_W-1:0] status_byte
);

    logic [SEL_W-1:0] stage;
    logic             active;
    logic [STG_N-1:0] count;
    logic [STG_N-1:0] rise;
    logic [PAD_W-1:0] count_pad;
    logic [PAD_W-1:0] rise_pad;
    logic             sq_level;
    logic             rise_sel;
    logic             flag;

    prdsel_rate_decode #(.CODE_W(CODE_W), .STG_N(STG_N)) i_dec (
        .code   (rate_code),
        .stage  (stage),
        .active (active)
    );

    prdsel_divider #(.STG_N(STG_N)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_32k),
        .count (count),
        .rise  (rise)
    );

    always_comb begin
        count_pad = PAD_W'(count);
        rise_pad  = PAD_W'(rise);
        sq_level  = active & count_pad[stage];
        rise_sel  = rise_pad[stage];
        sqw_drive = sqw_enable | fast_override;
        sqw_out   = sqw_drive & (fast_override ? tick_32k : sq_level);
    end

    prdsel_flag i_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_sel (rise_sel),
        .active   (active),
        .override (fast_override),
        .pie      (pflag_enable),
        .stat_rd  (status_read),
        .ptick    (periodic_tick),
        .flag     (flag),
        .irq      (irq)
    );

    assign status_byte = {irq, flag, {(STATUS_W-2){1'b0}}};

    // R5
    tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_tick |-> $past(tick_32k));

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_tick |=> !periodic_tick);

endmodule

// File: tb/test_prdsel_top.sv
module test_prdsel_top;

    localparam int MASK = (1 << 14) - 1;
    localparam int NVEC = 15;
    // {code, expected divider stage}
    localparam int VEC [NVEC][2] = '{
        '{3, 1}, '{4, 2}, '{1, 6}, '{5, 3}, '{6, 4}, '{2, 7}, '{7, 5},
        '{8, 6}, '{9, 7}, '{10, 8}, '{11, 9}, '{12, 10}, '{13, 11},
        '{14, 12}, '{15, 13}
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick_32k = 0;
    logic [3:0] rate_code = 0;
    logic       sqw_enable = 0;
    logic       fast_override = 0;
    logic       pflag_enable = 0;
    logic       status_read = 0;
    logic       sqw_out, sqw_drive, periodic_tick, irq;
    logic [7:0] status_byte;

    int  checks = 0;
    int  errors = 0;
    int  n = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    prdsel_top i_prdsel_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_32k      (tick_32k),
        .rate_code     (rate_code),
        .sqw_enable    (sqw_enable),
        .fast_override (fast_override),
        .pflag_enable  (pflag_enable),
        .status_read   (status_read),
        .sqw_out       (sqw_out),
        .sqw_drive     (sqw_drive),
        .periodic_tick (periodic_tick),
        .irq           (irq),
        .status_byte   (status_byte)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One tick, optionally with a status read in the same cycle.
    // Returns whether stage k rises on it (k < 0: no stage).
    task automatic step(input int k, input bit rd, output bit rose);
        int nx;
        @(negedge clk);
        tick_32k = 1;
        status_read = rd;
        nx = (n + 1) & MASK;
        rose = (k >= 0) && (((n >> k) & 1) == 0) && (((nx >> k) & 1) == 1);
        @(negedge clk);
        tick_32k = 0;
        status_read = 0;
        n = nx;
        #1;
    endtask

    task automatic read_clear();
        @(negedge clk);
        status_read = 1;
        @(negedge clk);
        status_read = 0;
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit rose;
        int bad;
        int rises;
        int seen;

        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        chk(periodic_tick == 0, "R10", "periodic_tick", periodic_tick, 0);
        chk(irq == 0, "R10", "irq", irq, 0);
        chk(status_byte == 8'h00, "R10", "status_byte", status_byte, 0);
        chk(sqw_out == 0, "R10", "sqw_out", sqw_out, 0);
        @(negedge clk);
        rst_n = 1;

        // R2 R3 R5: table walk, sqw and tick phase against model count
        sqw_enable = 1;
        for (int v = 0; v < NVEC; v++) begin
            int k;
            k = VEC[v][1];
            @(negedge clk);
            rate_code = 4'(VEC[v][0]);
            bad = 0;
            rises = 0;
            for (int t = 0; t < (2 << k) + 1; t++) begin
                step(k, 0, rose);
                if (rose) rises++;
                if (periodic_tick !== rose) bad++;
                if (sqw_out !== 1'(((n >> k) & 1))) bad++;
            end
            chk(bad == 0, (VEC[v][0] < 3) ? "R3" : "R2", "phase mismatches", bad, 0);
            chk(rises >= 1, "R5", "rises in window", rises, 1);
        end

        // R4 code 0: no output, no tick, no flag
        pflag_enable = 1;
        rate_code = 0;
        read_clear();
        bad = 0;
        for (int t = 0; t < 40; t++) begin
            step(-1, 0, rose);
            if (periodic_tick !== 0 || sqw_out !== 0) bad++;
        end
        chk(bad == 0, "R4", "code 0 activity", bad, 0);
        chk(status_byte == 8'h00, "R4", "flag after code 0", status_byte, 0);
        chk(sqw_drive == 1, "R6", "sqw_drive with enable", sqw_drive, 1);

        // R6 output disabled, periodic path still runs
        rate_code = 3;
        sqw_enable = 0;
        bad = 0;
        seen = 0;
        for (int t = 0; t < 8; t++) begin
            step(1, 0, rose);
            if (sqw_out !== 0 || sqw_drive !== 0) bad++;
            if (periodic_tick) seen++;
        end
        chk(bad == 0, "R6", "disabled output activity", bad, 0);
        chk(seen == 2, "R5", "ticks with output disabled", seen, 2);
        chk(status_byte == 8'hC0, "R9", "status with flag and enable", status_byte, 8'hC0);

        // R8 read clears
        read_clear();
        chk(status_byte == 8'h00, "R8", "status after read", status_byte, 0);

        // R9 enable masking
        pflag_enable = 0;
        rose = 0;
        while (!rose) step(1, 0, rose);
        chk(status_byte == 8'h40, "R9", "status with enable off", status_byte, 8'h40);
        chk(irq == 0, "R9", "irq with enable off", irq, 0);
        @(negedge clk);
        pflag_enable = 1;
        #1;
        chk(irq == 1, "R9", "irq after enable", irq, 1);

        // R8 set wins over a read in the same cycle
        read_clear();
        rose = 0;
        while (!rose) begin
            int nx;
            nx = (n + 1) & MASK;
            step(1, (((n >> 1) & 1) == 0) && (((nx >> 1) & 1) == 1), rose);
        end
        chk(status_byte[6] == 1, "R8", "flag after set with read", status_byte[6], 1);

        // R7 override: irq masked immediately
        @(negedge clk);
        fast_override = 1;
        #1;
        chk(irq == 0, "R7", "irq under override", irq, 0);
        chk(sqw_drive == 1, "R7", "drive under override", sqw_drive, 1);
        read_clear();
        @(negedge clk);
        tick_32k = 1;
        #1;
        chk(sqw_out == 1, "R7", "sqw_out follows tick high", sqw_out, 1);
        @(negedge clk);
        tick_32k = 0;
        n = (n + 1) & MASK;
        #1;
        chk(sqw_out == 0, "R7", "sqw_out follows tick low", sqw_out, 0);
        bad = 0;
        for (int t = 0; t < 8; t++) begin
            step(1, 0, rose);
            if (periodic_tick !== 0) bad++;
        end
        chk(bad == 0, "R7", "ticks under override", bad, 0);
        chk(status_byte == 8'h00, "R7", "flag under override", status_byte, 0);
        rate_code = 0;
        @(negedge clk);
        tick_32k = 1;
        #1;
        chk(sqw_out == 1, "R7", "override with code 0", sqw_out, 1);
        @(negedge clk);
        tick_32k = 0;
        n = (n + 1) & MASK;
        fast_override = 0;

        // R10 R1 mid-run reset restarts the divider
        rate_code = 3;
        sqw_enable = 1;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        #1;
        chk(status_byte == 8'h00, "R10", "status in reset", status_byte, 0);
        chk(sqw_out == 0, "R10", "sqw_out in reset", sqw_out, 0);
        rst_n = 1;
        n = 0;
        step(1, 0, rose);
        chk(periodic_tick == 0 && sqw_out == 0, "R1", "count 1 after reset",
            {periodic_tick, sqw_out}, 0);
        step(1, 0, rose);
        chk(periodic_tick == 1 && sqw_out == 1, "R1", "count 2 after reset",
            {periodic_tick, sqw_out}, 3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule